// File: doc/BRIEF.md
# Synchronised Dual-Port Sample Demultiplexer

The block takes a stream of signed samples, one per clock, and spreads them over two 8-bit output ports, A and B, so that each port changes at half the input clock rate. Every sample is first limited to the 8-bit range and coded as offset binary or two's complement. It then travels through a fixed-depth pipeline and leaves on one port or the other. In interleaved mode the two ports take turns, one on each clock. In parallel mode the two samples of a pair leave on the same clock: the earlier sample on A and the later one on B.

An active-low sync input decides which samples pair up. A falling edge marks the sample that must leave on port A. While the input stays high, both ports keep their last values. A half-rate data clock marks the clocks on which port A is written, so a receiver can latch the ports on it. Power-down and the data-clock disable are modelled as output-enable flags, not as high-impedance pins.

Top module: `pingpong_demux`

## Requirements
- R1: While reset is active, port_a and port_b read 0x00 and dco reads 0.
- R2: With no sync fall since reset, the first sample taken after reset is assigned to port A, and the assignment alternates A, B, A, B from there.
- R3: sync_n passes through two flops. If sync_n is first sampled low at edge t, after being sampled high at edge t-1, the sample taken at edge t+2 is assigned to A and the sample at t+3 to B.
- R4: With par_mode=0 (interleaved), a sample taken at edge k is written to its port at edge k+LAT (LAT=8 by default). The other port keeps its value on that edge.
- R5: With par_mode=1, when sample k is assigned to A and sample k+1 to B, both are written at edge k+LAT+1: port A a latency of LAT+1 and port B a latency of LAT. Any other sample is never written to a port.
- R6: If sync_n was sampled high at edge e-2, neither port changes at edge e.
- R7: fmt_twos=0 gives offset binary (value+128, mid-scale 0x80). fmt_twos=1 gives two's complement (mid-scale 0x00), which is the offset code with bit 7 inverted. The format is applied when the sample is taken.
- R8: Inputs above +127 are limited to +127 (0xFF offset, 0x7F two's). Inputs below -128 are limited to -128 (0x00 offset, 0x80 two's).
- R9: dco is 1 after the edges that write port A (interleaved) or write a pair (parallel), and 0 after every other edge. It keeps running while the ports are held. dco_oe follows dco_en.
- R10: data_oe is the inverse of pwr_dn, with no clock delay. The pipeline keeps running during power-down.
- R11: A second sync fall restarts the A/B assignment from the sample chosen by R3, even if the previous sample was also assigned to A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | IN_W | Signed input sample |
| sync_n | input | 1 | Active-low data sync; a fall sets the A phase, high holds the ports |
| par_mode | input | 1 | 0 interleaved, 1 parallel |
| fmt_twos | input | 1 | 0 offset binary, 1 two's complement |
| dco_en | input | 1 | Data clock output enable |
| pwr_dn | input | 1 | Power-down, removes the data output enable |
| port_a | output | OUT_W | Port A data |
| port_b | output | OUT_W | Port B data |
| data_oe | output | 1 | Data output enable |
| dco | output | 1 | Half-rate data clock |
| dco_oe | output | 1 | Data clock output enable |

## Verification
The bench builds the block with the defaults IN_W=10, OUT_W=8 and LAT=8. The 10-bit input can express values beyond the 8-bit range, so both limits of R8 can be driven, in either format. With LAT at 8, the exact 8-cycle and 9-cycle latencies can be checked cycle by cycle against a behavioural model. That model also follows sync falls at single-cycle spacing and single-cycle holds.

// File: rtl/pingpong_demux.sv
module pingpong_demux #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 8,
  parameter int LAT   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] din,
  input  logic                   sync_n,
  input  logic                   par_mode,
  input  logic                   fmt_twos,
  input  logic                   dco_en,
  input  logic                   pwr_dn,
  output logic [OUT_W-1:0]       port_a,
  output logic [OUT_W-1:0]       port_b,
  output logic                   data_oe,
  output logic                   dco,
  output logic                   dco_oe
);
  localparam int MAXV = (2 ** (OUT_W - 1)) - 1;
  localparam int MINV = -(2 ** (OUT_W - 1));
  localparam logic signed [IN_W-1:0] HI_LIM = MAXV[IN_W-1:0];
  localparam logic signed [IN_W-1:0] LO_LIM = MINV[IN_W-1:0];
  localparam logic [OUT_W-1:0] MSB = {1'b1, {(OUT_W-1){1'b0}}};

  logic [2:0]       sync_q;
  logic             fall, hold, last_b, new_b;
  logic [OUT_W-1:0] tc_val, code;
  logic [OUT_W-1:0] data_q [LAT+1];
  logic [LAT:0]     tag_q, vld_q;
  logic             wr_a_il, wr_b_il, wr_pair;

  assign fall  = sync_q[2] & ~sync_q[1];
  assign hold  = sync_q[1];
  assign new_b = fall ? 1'b0 : ~last_b;

  assign tc_val = (din > HI_LIM) ? ~MSB :
                  (din < LO_LIM) ? MSB  : din[OUT_W-1:0];
  assign code   = fmt_twos ? tc_val : (tc_val ^ MSB);

  assign wr_a_il = vld_q[LAT-1] & ~tag_q[LAT-1];
  assign wr_b_il = vld_q[LAT-1] &  tag_q[LAT-1];
  assign wr_pair = wr_b_il & vld_q[LAT] & ~tag_q[LAT];

  assign data_oe = ~pwr_dn;
  assign dco_oe  = dco_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_b <= 1'b1;
    end else begin
      sync_q <= {sync_q[1:0], sync_n};
      last_b <= new_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j <= LAT; j++) data_q[j] <= '0;
      tag_q <= '0;
      vld_q <= '0;
    end else begin
      data_q[0] <= code;
      for (int j = 1; j <= LAT; j++) data_q[j] <= data_q[j-1];
      tag_q <= {tag_q[LAT-1:0], new_b};
      vld_q <= {vld_q[LAT-1:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_a <= '0;
      port_b <= '0;
      dco    <= 1'b0;
    end else begin
      dco <= par_mode ? wr_pair : wr_a_il;
      if (!hold) begin
        if (par_mode) begin
          if (wr_pair) begin
            port_a <= data_q[LAT];
            port_b <= data_q[LAT-1];
          end
        end else begin
          if (wr_a_il) port_a <= data_q[LAT-1];
          if (wr_b_il) port_b <= data_q[LAT-1];
        end
      end
    end
  end
endmodule

// File: rtl/pingpong_demux_chk.sv
module pingpong_demux_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold_q,
  input logic             par_mode,
  input logic [OUT_W-1:0] port_a,
  input logic [OUT_W-1:0] port_b,
  input logic             dco
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> ($stable(port_a) && $stable(port_b)));

  p_a_on_dco_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_a) |-> dco);

  p_b_inter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !$stable(port_b)) |-> !dco);

  p_b_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && !$stable(port_b)) |-> dco);

  p_pair_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode && dco) |=> !dco);
endmodule

bind pingpong_demux pingpong_demux_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_q(sync_q[1]), .par_mode(par_mode),
  .port_a(port_a), .port_b(port_b), .dco(dco)
);

// File: tb/tb_pingpong_demux.sv
module tb_pingpong_demux;
  localparam int L = 8;

  logic clk = 0, rst_n = 0;
  logic signed [9:0] din = 0;
  logic sync_n = 0, par_mode = 0, fmt_twos = 0, dco_en = 1, pwr_dn = 0;
  logic [7:0] port_a, port_b;
  logic data_oe, dco, dco_oe;

  pingpong_demux dut (
    .clk(clk), .rst_n(rst_n), .din(din), .sync_n(sync_n), .par_mode(par_mode),
    .fmt_twos(fmt_twos), .dco_en(dco_en), .pwr_dn(pwr_dn), .port_a(port_a),
    .port_b(port_b), .data_oe(data_oe), .dco(dco), .dco_oe(dco_oe)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, e = 0, ramp = 0;
  int din_at[1024], syn_at[1024], fmt_at[1024], par_at[1024], tag[1024], code[1024];
  int exp_a = 0, exp_b = 0, exp_dco = 0;
  string cur = "R2";

  function automatic int to_code(int v, int twos);
    int c;
    if (v > 127) v = 127;
    if (v < -128) v = -128;
    c = (v + 128) & 255;
    if (twos != 0) c = c ^ 128;
    return c;
  endfunction

  function automatic int syn(int idx);
    return (idx < 1) ? 0 : syn_at[idx];
  endfunction

  task automatic chk(string req, string what, int got, int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h (edge %0d)", req, what, got, expv, e);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) e = 0;
    else begin
      e = e + 1;
      din_at[e] = int'(din);
      syn_at[e] = int'(sync_n);
      fmt_at[e] = int'(fmt_twos);
      par_at[e] = int'(par_mode);
    end
  end

  always @(negedge clk) begin
    if (rst_n && e > 0) begin
      tag[0] = 1;
      tag[e] = (syn(e-3) == 1 && syn(e-2) == 0) ? 0 : 1 - tag[e-1];
      code[e] = to_code(din_at[e], fmt_at[e]);
      if (par_at[e] == 1) begin
        exp_dco = (e >= L + 2 && tag[e-L] == 1 && tag[e-L-1] == 0) ? 1 : 0;
        if (syn(e-2) == 0 && exp_dco == 1) begin
          exp_a = code[e-L-1];
          exp_b = code[e-L];
        end
      end else begin
        exp_dco = (e >= L + 1 && tag[e-L] == 0) ? 1 : 0;
        if (syn(e-2) == 0 && e >= L + 1) begin
          if (tag[e-L] == 0) exp_a = code[e-L];
          else exp_b = code[e-L];
        end
      end
      chk(cur, "port_a", int'(port_a), exp_a);
      chk(cur, "port_b", int'(port_b), exp_b);
      chk("R9", "dco", int'(dco), exp_dco);
      chk("R9", "dco_oe", int'(dco_oe), int'(dco_en));
      chk("R10", "data_oe", int'(data_oe), int'(!pwr_dn));
    end
  end

  task automatic tick(int v);
    @(posedge clk);
    #2;
    din = 10'(v);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #2;
    rst_n = 0;
    sync_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset port_a", int'(port_a), 0);
    chk("R1", "reset port_b", int'(port_b), 0);
    chk("R1", "reset dco", int'(dco), 0);
    exp_a = 0;
    exp_b = 0;
    exp_dco = 0;
    rst_n = 1;
  endtask

  task automatic run_ramp(int n, int step);
    for (int i = 0; i < n; i++) begin
      ramp = ramp + step;
      if (ramp > 120) ramp = -120;
      tick(ramp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    cur = "R2";
    run_ramp(12, 3);
    cur = "R4";
    run_ramp(20, 5);
    cur = "R6";
    sync_n = 1;
    run_ramp(6, 7);
    cur = "R3";
    sync_n = 0;
    run_ramp(20, 3);
    cur = "R11";
    sync_n = 1;
    run_ramp(1, 3);
    sync_n = 0;
    run_ramp(20, 3);

    do_reset();
    par_mode = 1;
    cur = "R5";
    run_ramp(25, 4);
    sync_n = 1;
    run_ramp(3, 4);
    sync_n = 0;
    run_ramp(25, 4);
    sync_n = 1;
    run_ramp(2, 4);
    sync_n = 0;
    run_ramp(20, 4);

    do_reset();
    par_mode = 0;
    fmt_twos = 1;
    cur = "R7";
    run_ramp(20, 6);
    cur = "R8";
    for (int i = 0; i < 22; i++) tick(-400 + 41 * i);
    fmt_twos = 0;
    for (int i = 0; i < 22; i++) tick(400 - 41 * i);
    cur = "R7";
    run_ramp(12, 6);

    cur = "R10";
    pwr_dn = 1;
    run_ramp(4, 2);
    pwr_dn = 0;
    cur = "R9";
    dco_en = 0;
    run_ramp(4, 2);
    dco_en = 1;
    run_ramp(12, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule